// File: doc/BRIEF.md
# External Event Timestamp Capture

This block records the exact moment at which a signal edge arrives on any of three external event inputs. A free-running 64-bit time value comes in on a port. Each event input is brought into the clock domain through a synchronizer, and its edges are detected there. When an enabled edge is seen, the channel copies the current time into its own 64-bit capture register and sets its status flag.

Software controls each channel through a small word-addressed register port. A control word chooses rising edges, falling edges or both, and turns on the channel's interrupt contribution. The status flags share one register and are cleared by writing 1 to the bit. A single interrupt line stays high while any flagged channel has its interrupt enabled.

The capture time is read as two 32-bit words. Reading the low word freezes a copy of the matching high word, so a low-then-high read pair always returns one coherent 64-bit value, even if a new capture lands between the two reads.

Top module: `evt_stamp_capture`

## Requirements
- R1: After reset, every control word, the status register and every capture word read as zero, and `irq` is low.
- R2: With control bit 0 set, a rising edge on the channel's input captures the time. With bit 0 set and bit 1 clear, a falling edge neither captures nor sets the channel's status bit.
- R3: With control bit 1 set, a falling edge captures the time. With bit 1 set and bit 0 clear, a rising edge neither captures nor sets the channel's status bit.
- R4: With control bits 0 and 1 both set, every transition of the input captures the time.
- R5: An input change that is set up before clock edge k produces a capture that holds the `time_i` value present at clock edge k+2.
- R6: A capture sets bit n of the status register (word address 4) for channel n. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a capture and a clear hit the same bit in the same cycle, the capture wins.
- R7: `irq` goes high one cycle after a status bit is set on a channel whose control bit 4 is 1. It stays low for captures on channels whose bit 4 is 0, and it falls one cycle after the last such status bit is cleared.
- R8: A new capture on a channel whose status bit is still set overwrites that channel's capture value.
- R9: Reading the low capture word of a channel (word address 8+2n) stores that channel's high half. The high capture word (address 9+2n) returns the stored copy until the low word is read again.
- R10: Writing zero to a control word disables the channel. Later edges on that input change neither its capture value nor its status bit.
- R11: Channel n's control word is at word address n. It reads back bits 0, 1 and 4 as written and every other bit as 0. Unmapped addresses read as zero, and read data appears on `rdata` one cycle after `rd_en`.
- R12: An edge on one channel's input does not alter any other channel's capture value or status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_i | input | TIME_W (64) | Free-running time value to be captured |
| evt_i | input | NUM_CH (3) | Asynchronous external event inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (4) | Register word address |
| wdata | input | DATA_W (32) | Register write data |
| rdata | output | DATA_W (32) | Registered read data, valid one cycle after `rd_en` |
| irq | output | 1 | Combined event interrupt, registered |

## Verification
The embedded properties assume that every event input is low during reset. Because the synchronizer resets to zero, an input that is already high would produce a spurious first rising edge. They also assume that `time_i` and the register port change only between clock edges. The stimulus holds all event inputs low through reset and drives every input shortly after a falling clock edge. It changes the time value only on falling edges, so the value present at each rising edge is known exactly. Event pulses are spaced several cycles apart, so the synchronizer resolves each transition on its own.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
  // control word bit positions
  localparam int CTL_RISE_BIT = 0;
  localparam int CTL_FALL_BIT = 1;
  localparam int CTL_IEN_BIT  = 4;

  // word address map
  localparam int STATUS_ADDR   = 4;
  localparam int CAP_BASE_ADDR = 8;

  typedef struct packed {
    logic ien;
    logic fall_en;
    logic rise_en;
  } evt_ctl_t;

  function automatic int cap_lo_addr(input int ch);
    return CAP_BASE_ADDR + 2 * ch;
  endfunction

  function automatic int cap_hi_addr(input int ch);
    return CAP_BASE_ADDR + 2 * ch + 1;
  endfunction
endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES;

  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [LAST:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[LAST-1:0], async_i};
  end

  assign rise_o =  sh_q[LAST-1] & ~sh_q[LAST];
  assign fall_o = ~sh_q[LAST-1] &  sh_q[LAST];
endmodule

// File: rtl/evt_chan.sv
module evt_chan
  import evt_stamp_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  evt_ctl_t          ctl_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              clr_i,
  input  logic              lo_rd_i,
  output logic [TIME_W-1:0] cap_o,
  output logic [DATA_W-1:0] snap_hi_o,
  output logic              stat_o
);
  localparam int HI_W = TIME_W - DATA_W;

  logic              hit;
  logic [TIME_W-1:0] cap_q;
  logic [DATA_W-1:0] snap_q;
  logic              stat_q;

  assign hit = (ctl_i.rise_en & rise_i) | (ctl_i.fall_en & fall_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      stat_q <= 1'b0;
      snap_q <= '0;
    end else begin
      if (hit) cap_q <= time_i;
      // a capture outranks a clear arriving in the same cycle
      stat_q <= hit | (stat_q & ~clr_i);
      if (lo_rd_i) snap_q <= DATA_W'(cap_q[TIME_W-1 -: HI_W]);
    end
  end

  assign cap_o     = cap_q;
  assign snap_hi_o = snap_q;
  assign stat_o    = stat_q;

  AST_STAT_FROM_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q) |-> $past(hit)); // R6
  AST_CAP_FLAGS_STATUS: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_q) |-> stat_q); // R8
  AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == '0) |=> $stable(cap_q)); // R10
  AST_SNAP_ON_LO_READ: assert property (@(posedge clk) disable iff (rst)
    !$stable(snap_q) |-> $past(lo_rd_i)); // R9
endmodule

// File: rtl/evt_stamp_capture.sv
module evt_stamp_capture
  import evt_stamp_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int TIME_W      = 64,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] time_i,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

  evt_ctl_t          ctl_q [NUM_CH];
  logic [TIME_W-1:0] cap_w [NUM_CH];
  logic [DATA_W-1:0] snap_w[NUM_CH];
  logic [NUM_CH-1:0] stat_w;
  logic [NUM_CH-1:0] ien_w;
  logic [NUM_CH-1:0] clr_w;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;

  // control words
  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (rst) begin
        ctl_q[c] <= '0;
      end else if (wr_en && addr == ADDR_W'(c)) begin
        ctl_q[c].rise_en <= wdata[CTL_RISE_BIT];
        ctl_q[c].fall_en <= wdata[CTL_FALL_BIT];
        ctl_q[c].ien     <= wdata[CTL_IEN_BIT];
      end
    end
  end

  assign clr_w = (wr_en && addr == STAT_A) ? wdata[NUM_CH-1:0] : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(cap_lo_addr(g));
    logic rise_s, fall_s;

    evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .async_i(evt_i[g]),
      .rise_o (rise_s),
      .fall_o (fall_s)
    );

    evt_chan #(.TIME_W(TIME_W), .DATA_W(DATA_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .ctl_i    (ctl_q[g]),
      .rise_i   (rise_s),
      .fall_i   (fall_s),
      .time_i   (time_i),
      .clr_i    (clr_w[g]),
      .lo_rd_i  (rd_en && addr == LO_A),
      .cap_o    (cap_w[g]),
      .snap_hi_o(snap_w[g]),
      .stat_o   (stat_w[g])
    );

    assign ien_w[g] = ctl_q[g].ien;
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(c)) begin
        rd_mux[CTL_RISE_BIT] = ctl_q[c].rise_en;
        rd_mux[CTL_FALL_BIT] = ctl_q[c].fall_en;
        rd_mux[CTL_IEN_BIT]  = ctl_q[c].ien;
      end
      if (addr == ADDR_W'(cap_lo_addr(c))) rd_mux = cap_w[c][DATA_W-1:0];
      if (addr == ADDR_W'(cap_hi_addr(c))) rd_mux = snap_w[c];
    end
    if (addr == STAT_A) rd_mux = DATA_W'(stat_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rd_mux;
      irq_q <= |(stat_w & ien_w);
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|stat_w)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata)); // R11
endmodule

// File: tb/evt_stamp_capture_bench.sv
module evt_stamp_capture_bench;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] tcnt = 64'd100;
  logic [63:0] toff = 64'd0;
  logic [63:0] time_i;
  logic [2:0]  evt_i = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int tests = 0, fails = 0;

  typedef struct { int ch; logic [63:0] val; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(negedge clk) tcnt = tcnt + 1;
  assign time_i = tcnt + toff;

  evt_stamp_capture u_evt_stamp_capture (
    .clk(clk), .rst(rst), .time_i(time_i), .evt_i(evt_i),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    @(negedge clk); #1;
    rd_en = 1'b1; addr = 4'(a);
    @(negedge clk); #1;
    rd_en = 1'b0;
    d = rdata;
  endtask

  // driver: apply a level, push the expected capture when one is due
  task automatic drive_evt(input int ch, input logic lvl, input bit expect_cap);
    exp_t e;
    @(negedge clk); #1;
    evt_i[ch] = lvl;
    if (expect_cap) begin
      e.ch = ch; e.val = time_i + 64'd2;   // R5: two sync stages
      exp_q.push_back(e);
    end
    idle(5);
  endtask

  // monitor: pop expected captures and compare against the read-back
  task automatic drain(input string req);
    logic [31:0] lo, hi;
    exp_t e;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      bus_rd(8 + 2 * e.ch, lo);
      bus_rd(9 + 2 * e.ch, hi);
      chk(req, {hi, lo}, e.val);
    end
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(req, 64'(d), 64'(exp));
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, lo_a, hi_a;
    logic [63:0] cap0, cap1;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 irq", 64'(irq), 64'd0);
    rd_chk("R1 ctl0", 0, 32'h0);
    rd_chk("R1 status", 4, 32'h0);
    rd_chk("R1 cap0 lo", 8, 32'h0);
    rd_chk("R1 cap2 hi", 13, 32'h0);

    // R11 control readback and unmapped address
    bus_wr(0, 32'hFFFF_FFFF);
    rd_chk("R11 ctl mask", 0, 32'h13);
    rd_chk("R11 unmapped", 6, 32'h0);
    bus_wr(0, 32'h1);   // rise only

    // R2 / R5 rising capture on ch0
    drive_evt(0, 1'b1, 1);
    drain("R5 ch0 rise time");
    rd_chk("R6 status set", 4, 32'h1);
    chk("R7 no irq when disabled", 64'(irq), 64'd0);
    bus_wr(4, 32'h0);
    rd_chk("R6 write zero keeps", 4, 32'h1);
    bus_wr(4, 32'h1);
    rd_chk("R6 w1c clears", 4, 32'h0);
    bus_rd(8, d); cap0 = 64'(d);
    drive_evt(0, 1'b0, 0);   // falling edge ignored
    rd_chk("R2 fall ignored status", 4, 32'h0);
    rd_chk("R2 fall ignored cap", 8, cap0[31:0]);

    // R3 falling with interrupt on ch1
    bus_wr(1, 32'h12);
    drive_evt(1, 1'b1, 0);
    rd_chk("R3 rise ignored status", 4, 32'h0);
    chk("R3 rise ignored irq", 64'(irq), 64'd0);
    drive_evt(1, 1'b0, 1);
    chk("R7 irq raised", 64'(irq), 64'd1);
    drain("R3 ch1 fall time");
    rd_chk("R12 ch0 untouched", 8, cap0[31:0]);
    rd_chk("R12 status only ch1", 4, 32'h2);
    bus_wr(4, 32'h2);
    idle(2);
    chk("R7 irq drops", 64'(irq), 64'd0);

    // R4 both edges on ch2
    bus_wr(2, 32'h3);
    drive_evt(2, 1'b1, 1);
    drain("R4 ch2 rise");
    drive_evt(2, 1'b0, 1);
    drain("R4 ch2 fall");
    // R8 overwrite while status still set
    rd_chk("R8 status pending", 4, 32'h4);
    drive_evt(2, 1'b1, 1);
    drain("R8 ch2 overwrite");

    // R9 coherent snapshot on ch0
    bus_wr(4, 32'h7);
    toff = 64'h0000_0005_0000_0000;
    drive_evt(0, 1'b1, 1);
    cap0 = exp_q[0].val;
    void'(exp_q.pop_front());
    bus_rd(8, lo_a);
    toff = 64'h0000_0009_0000_0000;
    drive_evt(0, 1'b0, 0);
    drive_evt(0, 1'b1, 1);
    cap1 = exp_q[0].val;
    void'(exp_q.pop_front());
    bus_rd(9, hi_a);
    chk("R9 old lo", 64'(lo_a), 64'(cap0[31:0]));
    chk("R9 hi from snapshot", 64'(hi_a), 64'(cap0[63:32]));
    bus_rd(8, lo_a);
    bus_rd(9, hi_a);
    chk("R9 new pair", {hi_a, lo_a}, cap1);

    // R10 zero control disables ch2
    bus_wr(2, 32'h0);
    rd_chk("R10 ctl default", 2, 32'h0);
    bus_wr(4, 32'h7);
    bus_rd(12, d);
    drive_evt(2, 1'b0, 0);
    drive_evt(2, 1'b1, 0);
    rd_chk("R10 status stays", 4, 32'h0);
    rd_chk("R10 cap stays", 12, d);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule